// File: doc/BRIEF.md
# Grouped Multiply-Accumulate Array for Convolution

This block is the arithmetic core of a convolution engine. It is a grid of ROWS×COLS spatial groups, and each group holds DEPTH multiply-accumulate elements. Every group is fed one feature-map pixel per cycle. All elements of that group share the pixel, and each element computes a different output channel. The DEPTH kernel weights that arrive each cycle are shared by the same-index element across all groups. Each element keeps its partial sum in its own accumulator. Each product is added directly to that stored sum, so the block needs no adder tree.

A layer step sequence starts with a pulse that loads the bias of each output channel into every accumulator. Accumulate cycles then follow, one for each kernel tap and input channel. A final accumulate cycle is marked as the last one. Two clock edges later, all ROWS×COLS×DEPTH results are presented together with a one-cycle valid strobe. Each result is shifted right by a per-layer fractional shift and saturated to 16-bit signed. The results hold until the next drain.

Top module: `pe_group_array`

## Requirements
- R1: While reset is low and in the first cycle after it, `valid_o` is 0 and every field of `res_o` is 0.
- R2: A cycle with `start_i`=1 and `acc_en_i`=1 sets each accumulator to (bias << shift) + pixel×weight. `bias_i` field d (bits d*16 +: 16) is the bias of output channel d, in the output fixed-point format.
- R3: Each cycle with `acc_en_i`=1 and `start_i`=0 adds pixel×weight to each accumulator. A cycle with both low leaves all accumulators unchanged, whatever the pixel and weight inputs carry.
- R4: Group g = r*COLS + c takes its pixel from `pix_i` bits g*16 +: 16. Channel d takes its weight from `wgt_i` bits d*16 +: 16. The result of group g, channel d appears on `res_o` bits (g*DEPTH + d)*16 +: 16. All values are two's complement.
- R5: A cycle with `acc_en_i`=1 and `last_i`=1 makes `valid_o` high exactly two clock edges later, for one cycle per such step. Back-to-back last steps give back-to-back strobes, and each strobe carries the sums of its own step even when a new step has already started.
- R6: Each drained result equals floor(accumulator / 2^`frac_sh_i`), using arithmetic shift toward minus infinity.
- R7: A shifted result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R8: `res_o` changes only in a cycle where `valid_o` is high, and otherwise holds its last drained value.
- R9: A `start_i` cycle with `acc_en_i`=0 discards any earlier sums and leaves exactly bias << shift in each accumulator.
- R10: `last_i` without `acc_en_i` has no effect: it raises no valid strobe and leaves `res_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load bias into all accumulators |
| acc_en_i | input | 1 | Accumulate the current products |
| last_i | input | 1 | Marks the final accumulate step |
| frac_sh_i | input | SHW | Per-layer right shift used for the bias load and the drain |
| pix_i | input | ROWS*COLS*DW | One pixel per group |
| wgt_i | input | DEPTH*DW | One weight per output channel |
| bias_i | input | DEPTH*DW | One bias per output channel |
| res_o | output | ROWS*COLS*DEPTH*DW | Saturated results, group-major |
| valid_o | output | 1 | One-cycle strobe marking new results |

## Verification
The bench drives the array with several input patterns:
- Distinct pixels per group and distinct weights per channel, which expose any swap between the group mapping and the channel mapping.
- Long random accumulations with idle cycles carrying garbage inputs, which separate a true hold from an accidental accumulate.
- Odd negative sums under a non-zero shift, which separate floor from truncation toward zero.
- Extreme products, which reach both saturation limits.
- Back-to-back last steps, which show whether the drain captures the finished sums or the sums of the step that has just restarted.
- A bias reload without accumulation, and lone last strobes, which show that stale sums and unqualified last pulses leave no trace.

// File: rtl/pga_pkg.sv
// Shared types for the grouped multiply-accumulate array.
// Assumes: one operation code is broadcast to every processing element.
package pga_pkg;
    typedef enum logic [1:0] {
        OP_HOLD     = 2'b00,
        OP_ADD      = 2'b01,
        OP_LOAD     = 2'b10,
        OP_LOAD_ADD = 2'b11
    } pe_op_e;
endpackage

// File: rtl/pga_ctrl.sv
// Control for the array: decodes the strobes into a per-cycle
// accumulator operation and times the drain and valid pipeline.
// Assumes: last_i counts only together with acc_en_i.
module pga_ctrl
    import pga_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   acc_en_i,
    input  logic   last_i,
    output pe_op_e op_o,
    output logic   drain_o,
    output logic   valid_o
);
    logic drain_q;
    logic valid_q;

    // Map the start and accumulate strobes to an operation.
    always_comb begin
        unique case ({start_i, acc_en_i})
            2'b11:   op_o = OP_LOAD_ADD;
            2'b10:   op_o = OP_LOAD;
            2'b01:   op_o = OP_ADD;
            default: op_o = OP_HOLD;
        endcase
    end

    // Delay the final-step marker: one edge to drain, one more to present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_q <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            drain_q <= acc_en_i & last_i;
            valid_q <= drain_q;
        end
    end

    assign drain_o = drain_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/pga_pe.sv
// One processing element: a signed multiply feeding a local accumulator.
// The accumulator is preloaded with the shifted bias. On drain, the sum
// is shifted right arithmetically and saturated into a held output register.
// Assumes: ACC_W >= DW + 2**SHW, so the shifted bias cannot overflow.
module pga_pe
    import pga_pkg::*;
#(
    parameter int DW    = 16,
    parameter int ACC_W = 48,
    parameter int SHW   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  pe_op_e               op_i,
    input  logic                 drain_i,
    input  logic [SHW-1:0]       sh_i,
    input  logic signed [DW-1:0] pix_i,
    input  logic signed [DW-1:0] wgt_i,
    input  logic signed [DW-1:0] bias_i,
    output logic [DW-1:0]        res_o
);
    localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [2*DW-1:0]  prod;
    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] bias_ext;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] shifted;
    logic [DW-1:0]           sat_val;
    logic [DW-1:0]           res_q;

    // Form the sign-extended product and the aligned bias.
    always_comb begin
        prod     = pix_i * wgt_i;
        prod_ext = ACC_W'(prod);
        bias_ext = ACC_W'(bias_i) <<< sh_i;
    end

    // Update the local partial sum in place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            unique case (op_i)
                OP_LOAD_ADD: acc_q <= bias_ext + prod_ext;
                OP_LOAD:     acc_q <= bias_ext;
                OP_ADD:      acc_q <= acc_q + prod_ext;
                default:     acc_q <= acc_q;
            endcase
        end
    end

    // Scale the finished sum and clamp it to the output range.
    always_comb begin
        shifted = acc_q >>> sh_i;
        if (shifted > SAT_HI)      sat_val = SAT_HI[DW-1:0];
        else if (shifted < SAT_LO) sat_val = SAT_LO[DW-1:0];
        else                       sat_val = shifted[DW-1:0];
    end

    // Capture the result on drain and hold it until the next drain.
    always_ff @(posedge clk) begin
        if (!rst_n)       res_q <= '0;
        else if (drain_i) res_q <= sat_val;
    end

    assign res_o = res_q;
endmodule

// File: rtl/pga_group.sv
// One spatial group: DEPTH processing elements that share a single pixel,
// each with its own weight and bias for one output channel.
// Assumes: weight and bias vectors are channel-major, DW bits per channel.
module pga_group
    import pga_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int DW    = 16,
    parameter int ACC_W = 48,
    parameter int SHW   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  pe_op_e                op_i,
    input  logic                  drain_i,
    input  logic [SHW-1:0]        sh_i,
    input  logic [DW-1:0]         pix_i,
    input  logic [DEPTH*DW-1:0]   wgt_i,
    input  logic [DEPTH*DW-1:0]   bias_i,
    output logic [DEPTH*DW-1:0]   res_o
);
    // One element per output channel, all fed the same pixel.
    for (genvar d = 0; d < DEPTH; d++) begin : g_pe
        pga_pe #(.DW(DW), .ACC_W(ACC_W), .SHW(SHW)) u_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .op_i    (op_i),
            .drain_i (drain_i),
            .sh_i    (sh_i),
            .pix_i   (pix_i),
            .wgt_i   (wgt_i[d*DW +: DW]),
            .bias_i  (bias_i[d*DW +: DW]),
            .res_o   (res_o[d*DW +: DW])
        );
    end
endmodule

// File: rtl/pe_group_array.sv
// Top of the grouped multiply-accumulate array: ROWS x COLS groups of
// DEPTH elements. Pixels are broadcast within a group, and weights are
// shared by the same channel across all groups.
// Assumes: frac_sh_i stays constant from a bias load to its drain.
module pe_group_array
    import pga_pkg::*;
#(
    parameter int ROWS  = 9,
    parameter int COLS  = 9,
    parameter int DEPTH = 12,
    parameter int DW    = 16,
    parameter int ACC_W = 48,
    parameter int SHW   = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          acc_en_i,
    input  logic                          last_i,
    input  logic [SHW-1:0]                frac_sh_i,
    input  logic [ROWS*COLS*DW-1:0]       pix_i,
    input  logic [DEPTH*DW-1:0]           wgt_i,
    input  logic [DEPTH*DW-1:0]           bias_i,
    output logic [ROWS*COLS*DEPTH*DW-1:0] res_o,
    output logic                          valid_o
);
    localparam int GRP_BITS = DEPTH * DW;

    pe_op_e op;
    logic   drain;

    pga_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .acc_en_i (acc_en_i),
        .last_i   (last_i),
        .op_o     (op),
        .drain_o  (drain),
        .valid_o  (valid_o)
    );

    // Build the grid; group index g = r*COLS + c selects the pixel and result slots.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int G = r * COLS + c;
            pga_group #(.DEPTH(DEPTH), .DW(DW), .ACC_W(ACC_W), .SHW(SHW)) u_grp (
                .clk     (clk),
                .rst_n   (rst_n),
                .op_i    (op),
                .drain_i (drain),
                .sh_i    (frac_sh_i),
                .pix_i   (pix_i[G*DW +: DW]),
                .wgt_i   (wgt_i),
                .bias_i  (bias_i),
                .res_o   (res_o[G*GRP_BITS +: GRP_BITS])
            );
        end
    end
endmodule

// File: rtl/pga_checker.sv
// Protocol checks for the array, attached to the top by bind.
// Assumes: reset is synchronous and active low.
module pga_checker #(
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_en_i,
    input logic             last_i,
    input logic             valid_o,
    input logic [RES_W-1:0] res_o
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !valid_o); // R1

    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && last_i) |=> ##1 valid_o); // R5

    AST_VALID_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(acc_en_i && last_i, 2)); // R10

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(res_o)); // R8
endmodule

bind pe_group_array pga_checker #(.RES_W(ROWS*COLS*DEPTH*DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en_i (acc_en_i),
    .last_i   (last_i),
    .valid_o  (valid_o),
    .res_o    (res_o)
);

// File: tb/sim_pe_group_array.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle model of the accumulators and drain,
// compared against the outputs at every falling edge.
module sim_pe_group_array;
    localparam int R = 2, C = 2, D = 3, DW = 16, AW = 48, SW = 5;
    localparam int NG = R * C;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, start_i, acc_en_i, last_i;
    logic [SW-1:0]        frac_sh_i;
    logic [NG*DW-1:0]     pix_i;
    logic [D*DW-1:0]      wgt_i, bias_i;
    logic [NG*D*DW-1:0]   res_o;
    logic                 valid_o;

    pe_group_array #(.ROWS(R), .COLS(C), .DEPTH(D), .DW(DW), .ACC_W(AW), .SHW(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .acc_en_i(acc_en_i),
        .last_i(last_i), .frac_sh_i(frac_sh_i), .pix_i(pix_i), .wgt_i(wgt_i),
        .bias_i(bias_i), .res_o(res_o), .valid_o(valid_o)
    );

    longint acc_m [NG][D];
    longint res_m [NG][D];
    bit     done_m, valid_m;
    longint pixv [NG];
    longint wgtv [D];
    longint biasv [D];
    int     checks = 0, fails = 0;
    string  cur_req = "R1";
    bit     finished = 0;

    function automatic longint sat16(longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint rnd16();
        return longint'($urandom_range(65535)) - 32768;
    endfunction

    // Compare the outputs against the model state after the previous edge.
    task automatic check_outputs();
        string vtag, rtag;
        bit    bad = 0;
        vtag = (cur_req == "R1" || cur_req == "R10") ? cur_req : "R5";
        rtag = (cur_req == "R1") ? "R1" : (valid_m ? cur_req : "R8");
        checks++;
        if (valid_o !== valid_m) begin
            fails++;
            $display("FAIL %s valid_o actual %0b expected %0b", vtag, valid_o, valid_m);
        end
        checks++;
        for (int g = 0; g < NG; g++) begin
            for (int d = 0; d < D; d++) begin
                longint got;
                got = longint'($signed(res_o[(g*D+d)*DW +: DW]));
                if (!bad && got != res_m[g][d]) begin
                    bad = 1;
                    fails++;
                    $display("FAIL %s res group %0d channel %0d actual %0d expected %0d",
                             rtag, g, d, got, res_m[g][d]);
                end
            end
        end
    endtask

    // One cycle: check, drive the inputs, advance the model.
    task automatic step(bit st, bit ae, bit ls, int sh);
        @(negedge clk);
        check_outputs();
        start_i = st; acc_en_i = ae; last_i = ls; frac_sh_i = SW'(sh);
        for (int g = 0; g < NG; g++) pix_i[g*DW +: DW] = DW'(pixv[g]);
        for (int d = 0; d < D; d++) begin
            wgt_i[d*DW +: DW]  = DW'(wgtv[d]);
            bias_i[d*DW +: DW] = DW'(biasv[d]);
        end
        if (done_m)
            for (int g = 0; g < NG; g++)
                for (int d = 0; d < D; d++)
                    res_m[g][d] = sat16(acc_m[g][d] >>> sh);
        valid_m = done_m;
        done_m  = ae && ls;
        for (int g = 0; g < NG; g++)
            for (int d = 0; d < D; d++) begin
                longint p;
                p = pixv[g] * wgtv[d];
                if (st) acc_m[g][d] = (biasv[d] <<< sh) + (ae ? p : 0);
                else if (ae) acc_m[g][d] = acc_m[g][d] + p;
            end
    endtask

    task automatic randomize_data();
        for (int g = 0; g < NG; g++) pixv[g] = rnd16();
        for (int d = 0; d < D; d++) begin
            wgtv[d]  = rnd16();
            biasv[d] = rnd16();
        end
    endtask

    task automatic idle(int n, int sh);
        for (int i = 0; i < n; i++) begin
            randomize_data();
            step(0, 0, 0, sh);
        end
    endtask

    initial begin
        rst_n = 0; start_i = 0; acc_en_i = 0; last_i = 0; frac_sh_i = '0;
        pix_i = '0; wgt_i = '0; bias_i = '0;
        for (int g = 0; g < NG; g++) begin
            pixv[g] = 0;
            for (int d = 0; d < D; d++) begin acc_m[g][d] = 0; res_m[g][d] = 0; end
        end
        for (int d = 0; d < D; d++) begin wgtv[d] = 0; biasv[d] = 0; end
        done_m = 0; valid_m = 0;
        repeat (3) @(negedge clk);
        // R1: reset state visible at the ports
        cur_req = "R1";
        check_outputs();
        rst_n = 1;
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        // R2: single-step bias plus product
        cur_req = "R2";
        for (int g = 0; g < NG; g++) pixv[g] = 3 + g;
        for (int d = 0; d < D; d++) begin wgtv[d] = -2 - d; biasv[d] = 100 * (d + 1); end
        step(1, 1, 1, 0);
        idle(3, 0);

        // R4: distinct pixels per group, distinct weights per channel
        cur_req = "R4";
        for (int g = 0; g < NG; g++) pixv[g] = 1 << g;
        for (int d = 0; d < D; d++) begin wgtv[d] = 16 << (2 * d); biasv[d] = 0; end
        step(1, 1, 1, 0);
        idle(3, 0);

        // R3: multi-step accumulation with idle cycles carrying garbage
        cur_req = "R3";
        randomize_data();
        step(1, 1, 0, 8);
        for (int k = 0; k < 5; k++) begin
            randomize_data();
            step(0, 1, 0, 8);
            randomize_data();
            step(0, 0, 0, 8);
        end
        randomize_data();
        step(0, 1, 1, 8);
        idle(3, 8);

        // R6: odd negative sums with a shift, floor rounding
        cur_req = "R6";
        for (int g = 0; g < NG; g++) pixv[g] = -7 - 2 * g;
        for (int d = 0; d < D; d++) begin wgtv[d] = 3 + 2 * d; biasv[d] = -3 + d; end
        step(1, 1, 0, 4);
        step(0, 1, 1, 4);
        idle(3, 4);

        // R7: saturation at both limits
        cur_req = "R7";
        for (int g = 0; g < NG; g++) pixv[g] = (g % 2 == 0) ? 32000 : -32000;
        for (int d = 0; d < D; d++) begin wgtv[d] = 30000; biasv[d] = 0; end
        step(1, 1, 0, 0);
        step(0, 1, 1, 0);
        idle(3, 0);

        // R9: bias reload without accumulate discards old sums
        cur_req = "R9";
        randomize_data();
        step(1, 1, 0, 2);
        randomize_data();
        step(0, 1, 0, 2);
        randomize_data();
        step(1, 0, 0, 2);
        randomize_data();
        step(0, 1, 1, 2);
        idle(3, 2);
        randomize_data();
        step(1, 0, 0, 3);
        step(0, 0, 0, 3);
        randomize_data();
        step(0, 1, 1, 3);
        idle(3, 3);

        // R5: back-to-back last steps, overlapping drain and restart
        cur_req = "R5";
        for (int k = 0; k < 4; k++) begin
            randomize_data();
            step(1, 1, 1, 2);
        end
        idle(4, 2);

        // R10: last without accumulate has no effect
        cur_req = "R10";
        for (int k = 0; k < 4; k++) begin
            randomize_data();
            step(0, 0, 1, 2);
        end
        idle(3, 2);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule